// File: doc/BRIEF.md
# Cascadable Decimal Counter Stage

This block is one decimal digit of a synchronous counter. It holds a 4-bit value that steps through 0 to 9 and then wraps to 0. It also has a synchronous preset path and two active-high count enables. The first enable, `cnt_en`, is meant for a shared run signal. The second enable, `chain_en`, is meant for the carry from the digit below. Only `chain_en` gates the terminal-count flag `tc`.

To build a multi-digit decimal counter, tie `cnt_en` of every stage to one common enable. Feed each stage's `tc` into the `chain_en` of the next stage up. All digits share one clock, so every digit changes on the same edge and no carry ripples through registers.

When several actions are requested at once, the stage resolves them in a fixed order: reset first, then preset, then count, then hold. The master reset clears the stage at once, without waiting for a clock edge. The release of the reset takes effect only at a clock edge. The stage ignores the first rising edge after release, so a count requested in that cycle is dropped.

Top module: `bcd_count_stage`

## Requirements
- R1: While `rst_n` is LOW, `q` is 0 and `tc` is LOW. This takes effect at once, without waiting for a clock edge, whatever the other inputs are.
- R2: Preset has priority over counting. At a rising edge with `rst_n` HIGH and `load_n` LOW, `q` takes the value of `preset`, whatever `cnt_en` and `chain_en` are.
- R3: At a rising edge with `load_n` HIGH, `cnt_en` HIGH and `chain_en` HIGH, `q` advances by one. From 9 it goes to 0.
- R4: At a rising edge with `load_n` HIGH and either `cnt_en` or `chain_en` LOW, `q` keeps its value.
- R5: `tc` is HIGH exactly when `chain_en` is HIGH and `q` equals 9 (binary 1001). `tc` is combinational, and `cnt_en` has no effect on it.
- R6: `q` changes only at a rising edge of `clk`. The one exception is reset assertion (R1). Input changes between edges leave `q` unchanged.
- R7: A preset value from 10 to 15 is accepted as loaded. The next enabled count from any such value gives 0.
- R8: The first rising edge after `rst_n` goes HIGH leaves `q` at 0, even if a preset or a count is requested in that cycle. Normal operation starts at the second edge.
- R9: Three stages can be chained, with each `tc` driving the next stage's `chain_en` and all `cnt_en` inputs tied together. Such a chain counts 000 to 999 in decimal and then wraps to 000. The top stage's `tc` is HIGH only at 999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| rst_n | input | 1 | Master reset, active low; asserts without a clock, releases at a clock edge |
| load_n | input | 1 | Synchronous preset enable, active low |
| preset | input | 4 | Value loaded into the digit on a preset |
| cnt_en | input | 1 | Count enable shared by all stages of a chain |
| chain_en | input | 1 | Count enable from the stage below; also gates `tc` |
| q | output | 4 | Current digit value |
| tc | output | 1 | Terminal count: HIGH when `chain_en` is HIGH and `q` is 9 |

## Verification
The hardest state to reach from the ports is the top digit of a chain reaching its terminal count. The top stage counts only when both lower stages are at 9 in the same cycle, so `tc` of the third stage goes HIGH only at 999. The bench reaches it by running a three-stage chain for more than a thousand enabled cycles. It checks the decimal value after every edge and checks the wrap back to 000. The out-of-range values 10 to 15 are also hard to reach, because counting alone never produces them; the bench gets there through the preset path and then counts once.

// File: rtl/bcd_stage_pkg.sv
package bcd_stage_pkg;

    // Action selected for the coming clock edge, in priority order after reset.
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_WAKE  = 2'd3
    } mode_e;

endpackage

// File: rtl/bcd_mode_dec.sv
module bcd_mode_dec
    import bcd_stage_pkg::*;
(
    input  logic  armed,
    input  logic  load_n,
    input  logic  cnt_en,
    input  logic  chain_en,
    output mode_e mode
);

    always_comb begin
        if (!armed) begin
            mode = MODE_WAKE;          // first edge after reset release does nothing
        end else if (!load_n) begin
            mode = MODE_LOAD;          // preset overrides counting
        end else if (cnt_en && chain_en) begin
            mode = MODE_COUNT;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/bcd_digit_next.sv
module bcd_digit_next
    import bcd_stage_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int LAST  = 9
) (
    input  logic [WIDTH-1:0] digit,
    input  logic [WIDTH-1:0] preset,
    input  mode_e            mode,
    output logic [WIDTH-1:0] digit_nx
);

    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    logic [WIDTH-1:0] stepped;

    // Any value at or above the last legal digit folds back to zero.
    always_comb begin
        stepped = (digit >= LAST_V) ? '0 : digit + 1'b1;
    end

    always_comb begin
        unique case (mode)
            MODE_LOAD:  digit_nx = preset;
            MODE_COUNT: digit_nx = stepped;
            default:    digit_nx = digit;
        endcase
    end

endmodule

// File: rtl/bcd_term_det.sv
module bcd_term_det #(
    parameter int WIDTH = 4,
    parameter int LAST  = 9
) (
    input  logic [WIDTH-1:0] digit,
    input  logic             chain_en,
    output logic             tc
);

    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    always_comb begin
        tc = chain_en && (digit == LAST_V);
    end

endmodule

// File: rtl/bcd_count_stage.sv
module bcd_count_stage
    import bcd_stage_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int LAST  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] q,
    output logic             tc
);

    localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

    typedef struct packed {
        logic             armed;
        logic [WIDTH-1:0] digit;
    } stage_t;

    stage_t           st_d;
    stage_t           st_q;
    mode_e            mode;
    logic [WIDTH-1:0] digit_nx;

    bcd_mode_dec u_mode_dec (
        .armed    (st_q.armed),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .mode     (mode)
    );

    bcd_digit_next #(
        .WIDTH (WIDTH),
        .LAST  (LAST)
    ) u_digit_next (
        .digit    (st_q.digit),
        .preset   (preset),
        .mode     (mode),
        .digit_nx (digit_nx)
    );

    bcd_term_det #(
        .WIDTH (WIDTH),
        .LAST  (LAST)
    ) u_term_det (
        .digit    (st_q.digit),
        .chain_en (chain_en),
        .tc       (tc)
    );

    always_comb begin
        st_d.armed = 1'b1;
        st_d.digit = digit_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.digit;

    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && !load_n) |=> (q == $past(preset))); // R2

    AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && load_n && cnt_en && chain_en)
        |=> (q == (($past(q) >= LAST_V) ? '0 : $past(q) + 1'b1))); // R3

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && load_n && !(cnt_en && chain_en)) |=> $stable(q)); // R4

    AST_NO_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> !tc); // R5

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> (q == '0)); // R8

endmodule

// File: tb/test_bcd_count_stage.sv
module test_bcd_count_stage;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] preset = 4'd0;
    logic       cnt_en = 1'b0;
    logic       chain_en = 1'b0;
    logic [3:0] q;
    logic       tc;

    logic       c_rst_n = 1'b0;
    logic       c_en = 1'b0;
    logic       c_one = 1'b1;
    logic       c_load_n = 1'b1;
    logic [3:0] c_preset = 4'd0;
    logic [3:0] q0, q1, q2;
    logic       tc0, tc1, tc2;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [3:0] m_q = 4'd0;
    logic       m_armed = 1'b0;

    always #5 clk = ~clk;

    bcd_count_stage i_bcd_count_stage (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .preset(preset),
        .cnt_en(cnt_en), .chain_en(chain_en), .q(q), .tc(tc)
    );

    bcd_count_stage i_bcd_count_stage_lo (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .preset(c_preset),
        .cnt_en(c_en), .chain_en(c_one), .q(q0), .tc(tc0)
    );

    bcd_count_stage i_bcd_count_stage_mid (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .preset(c_preset),
        .cnt_en(c_en), .chain_en(tc0), .q(q1), .tc(tc1)
    );

    bcd_count_stage i_bcd_count_stage_hi (
        .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .preset(c_preset),
        .cnt_en(c_en), .chain_en(tc1), .q(q2), .tc(tc2)
    );

    task automatic check(input string req, input logic [3:0] aq, input logic [3:0] eq,
                         input logic at, input logic et);
        n_vec++;
        if (aq !== eq || at !== et) begin
            n_bad++;
            $display("FAIL %s: q=%0d tc=%0b expected q=%0d tc=%0b", req, aq, at, eq, et);
        end
    endtask

    // Reference model: reset > preset > count > hold, first edge after release idle.
    task automatic tick(input string req);
        logic [3:0] nq;
        nq = m_q;
        if (m_armed) begin
            if (!load_n)                nq = preset;
            else if (cnt_en && chain_en) nq = (m_q >= 4'd9) ? 4'd0 : m_q + 4'd1;
        end
        @(posedge clk);
        #2;
        m_q = nq;
        m_armed = 1'b1;
        check(req, q, m_q, tc, chain_en && (m_q == 4'd9));
    endtask

    task automatic t_reset();
        cnt_en = 1'b1; chain_en = 1'b1; load_n = 1'b0; preset = 4'd7;
        repeat (2) begin
            @(posedge clk);
            #2;
            check("R1", q, 4'd0, tc, 1'b0);
        end
    endtask

    task automatic t_release();
        load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        rst_n = 1'b1;
        tick("R8");
        check("R8", q, 4'd0, tc, 1'b0);
        tick("R3");
    endtask

    task automatic t_count_wrap();
        load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
        repeat (23) tick("R3");
    endtask

    task automatic t_tc_gating();
        load_n = 1'b0; preset = 4'd9; tick("R2");
        load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1; #1;
        check("R5", q, 4'd9, tc, 1'b1);
        chain_en = 1'b0; #1;
        check("R5", q, 4'd9, tc, 1'b0);
        cnt_en = 1'b1; #1;
        check("R5", q, 4'd9, tc, 1'b0);
    endtask

    task automatic t_hold();
        load_n = 1'b0; preset = 4'd4; tick("R2");
        load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b1;
        repeat (3) tick("R4");
        cnt_en = 1'b1; chain_en = 1'b0;
        repeat (3) tick("R4");
        cnt_en = 1'b0;
        tick("R4");
        check("R4", q, 4'd4, tc, 1'b0);
    endtask

    task automatic t_preset_priority();
        cnt_en = 1'b1; chain_en = 1'b1; load_n = 1'b0;
        preset = 4'd2; tick("R2");
        preset = 4'd8; tick("R2");
        cnt_en = 1'b0; chain_en = 1'b0; preset = 4'd5; tick("R2");
        check("R2", q, 4'd5, tc, 1'b0);
    endtask

    task automatic t_out_of_range();
        for (int v = 10; v < 16; v++) begin
            load_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1; preset = 4'(v);
            tick("R7");
            check("R7", q, 4'(v), tc, 1'b0);
            load_n = 1'b1;
            tick("R7");
            check("R7", q, 4'd0, tc, 1'b0);
        end
    endtask

    task automatic t_edge_only();
        load_n = 1'b1; cnt_en = 1'b0; chain_en = 1'b0; preset = 4'd3;
        tick("R6");
        load_n = 1'b0; cnt_en = 1'b1; chain_en = 1'b1; #2;
        check("R6", q, m_q, tc, chain_en && (m_q == 4'd9));
        load_n = 1'b1; #1;
        check("R6", q, m_q, tc, chain_en && (m_q == 4'd9));
        tick("R6");
    endtask

    task automatic t_async_clear();
        load_n = 1'b0; preset = 4'd9; cnt_en = 1'b1; chain_en = 1'b1;
        tick("R2");
        load_n = 1'b1;
        rst_n = 1'b0; #1;
        check("R1", q, 4'd0, tc, 1'b0);
        m_q = 4'd0; m_armed = 1'b0;
        @(posedge clk); #2;
        check("R1", q, 4'd0, tc, 1'b0);
        rst_n = 1'b1;
        tick("R8");
        check("R8", q, 4'd0, tc, 1'b0);
    endtask

    task automatic t_cascade();
        int val;
        c_rst_n = 1'b1; c_en = 1'b1;
        @(posedge clk); #2;
        check("R9", q0, 4'd0, tc2, 1'b0);
        for (int k = 1; k <= 1004; k++) begin
            @(posedge clk); #2;
            val = k % 1000;
            n_vec++;
            if (q0 !== 4'(val % 10) || q1 !== 4'((val / 10) % 10) ||
                q2 !== 4'(val / 100) || tc2 !== (val == 999)) begin
                n_bad++;
                $display("FAIL R9: digits=%0d%0d%0d tc=%0b expected %0d tc=%0b",
                         q2, q1, q0, tc2, val, (val == 999));
            end
        end
        c_en = 1'b0;
        @(posedge clk); #2;
        check("R9", q0, 4'd4, tc2, 1'b0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: q=%0d tc=%0b expected run to finish", q, tc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1", q, 4'd0, tc, 1'b0);
        @(posedge clk); #2;
        t_reset();
        t_release();
        t_count_wrap();
        t_tc_gating();
        t_hold();
        t_preset_priority();
        t_out_of_range();
        t_edge_only();
        t_async_clear();
        t_cascade();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule